// File: doc/BRIEF.md
# Edge-Triggered Phase-Frequency Detector

This block compares a reference input with a feedback input from an oscillator. It looks only at the rising edges of the two inputs, so their duty cycles have no effect on the result. A fast system clock samples both inputs through synchronizers, and rising edges are found synchronously. Two internal flags remember which edge arrived first. The "up" flag is set by a reference edge. The "down" flag is set by a feedback edge. An edge on the opposite input clears the flag that is pending.

The output models a three-state charge-pump drive as two signals: a drive-enable and a drive-level. When the reference leads, the drive is high for as many clock cycles as the two edges are apart. When the feedback leads, the drive is low for that interval. In all other cases the drive is released, so the external filter holds its voltage. A separate phase flag is high whenever a correction is in progress. It is low only while the two inputs are in phase.

Top module: `edge_pfd`

## Requirements
- R1: The drive pulse width depends only on the distance between rising edges. A reference that is high for one clock cycle gives the same pulse as a reference that is high for many cycles.
- R2: A reference rising edge that comes d clock cycles before a feedback rising edge gives one pulse with drv_en=1 and drv_lvl=1, lasting exactly d cycles.
- R3: A feedback rising edge that comes d clock cycles before a reference rising edge gives one pulse with drv_en=1 and drv_lvl=0, lasting exactly d cycles.
- R4: While no correction is pending, the drive is released: drv_en=0 and drv_lvl=0.
- R5: Rising edges on both inputs in the same sampling cycle produce no drive pulse.
- R6: phase_flag equals drv_en in every cycle.
- R7: Further reference rising edges that arrive while the high drive is active neither end it nor restart it. Only a feedback rising edge ends it. This makes the detector respond to frequency as well as phase.
- R8: Pulling rst_n low releases the drive and clears phase_flag at once, without waiting for a clock edge. Drive pulses resume only after the input is released.
- R9: With the default two-stage synchronizer, an input rising edge that is first captured at clock edge k causes drv_en to rise at clock edge k+2.
- R10: The up and down flags are never both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside the block |
| ref_in | input | 1 | Asynchronous reference signal |
| fb_in | input | 1 | Asynchronous feedback signal from the oscillator |
| drv_en | output | 1 | Drive enable; 0 means the charge-pump output is released (high impedance) |
| drv_lvl | output | 1 | Drive level while drv_en=1: 1 pumps up, 0 pumps down; 0 while released |
| phase_flag | output | 1 | High while an up or down correction is in progress |

## Verification
Two events can fall in the same cycle: the setting of one flag and the clearing edge from the other input. When a new edge and the pending flag's terminating edge share a sampling cycle, the cancel rule decides the outcome. The bench provokes this by driving both rising edges at the same clock edge, both from rest and in the middle of an unequal-frequency run. It judges the result with a behavioural per-cycle model and by measuring each pulse length against the edge separation. A second case is reset assertion in the middle of a pulse. It is judged by sampling the outputs between clock edges, right after the reset falls.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  // Pending-correction flags held between rising edges
  typedef struct packed {
    logic up;
    logic dn;
  } pfd_flags_t;

  localparam int unsigned CH_REF = 0;
  localparam int unsigned CH_FB  = 1;
  localparam int unsigned N_CH   = 2;
endpackage

// File: rtl/pfd_rst_sync.sv
module pfd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/pfd_edge.sv
module pfd_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  // SYNC_STAGES synchronizer flops followed by one history flop
  localparam int unsigned DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] pipe_q;
  logic [DEPTH-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[DEPTH-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  // synchronized level is high now and was low one sample earlier
  assign rise = pipe_q[SYNC_STAGES-1] & ~pipe_q[SYNC_STAGES];
endmodule

// File: rtl/pfd_flags.sv
module pfd_flags
  import pfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rise_ref,
  input  logic       rise_fb,
  output pfd_flags_t flags
);
  pfd_flags_t flags_q;
  pfd_flags_t flags_d;
  logic       want_up;
  logic       want_dn;

  always_comb begin
    want_up = flags_q.up | rise_ref;
    want_dn = flags_q.dn | rise_fb;
    // Opposite demands cancel in the same cycle, so both flags are never held
    if (want_up && want_dn) begin
      flags_d.up = 1'b0;
      flags_d.dn = 1'b0;
    end else begin
      flags_d.up = want_up;
      flags_d.dn = want_dn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;
endmodule

// File: rtl/pfd_drive.sv
module pfd_drive
  import pfd_pkg::*;
(
  input  pfd_flags_t flags,
  output logic       drv_en,
  output logic       drv_lvl,
  output logic       phase_flag
);
  always_comb begin
    drv_en     = flags.up | flags.dn;
    drv_lvl    = flags.up;
    phase_flag = flags.up | flags.dn;
  end
endmodule

// File: rtl/edge_pfd.sv
module edge_pfd
  import pfd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic fb_in,
  output logic drv_en,
  output logic drv_lvl,
  output logic phase_flag
);
  logic             rst_int_n;
  logic [N_CH-1:0]  raw_in;
  logic [N_CH-1:0]  rise_vec;
  logic             rise_ref;
  logic             rise_fb;
  logic             flag_up;
  logic             flag_dn;
  pfd_flags_t       flags;

  pfd_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_int_n)
  );

  assign raw_in[CH_REF] = ref_in;
  assign raw_in[CH_FB]  = fb_in;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_edge
    pfd_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_int_n),
      .din   (raw_in[ch]),
      .rise  (rise_vec[ch])
    );
  end

  assign rise_ref = rise_vec[CH_REF];
  assign rise_fb  = rise_vec[CH_FB];

  pfd_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rise_ref (rise_ref),
    .rise_fb  (rise_fb),
    .flags    (flags)
  );

  assign flag_up = flags.up;
  assign flag_dn = flags.dn;

  pfd_drive u_drive (
    .flags      (flags),
    .drv_en     (drv_en),
    .drv_lvl    (drv_lvl),
    .phase_flag (phase_flag)
  );
endmodule

// File: rtl/edge_pfd_chk.sv
module edge_pfd_chk (
  input logic clk,
  input logic rst_n,
  input logic rise_ref,
  input logic rise_fb,
  input logic up,
  input logic dn,
  input logic drv_en,
  input logic drv_lvl
);
  // R10
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(up && dn));

  // R4
  release_chk: assert property (@(posedge clk) disable iff (!rst_n) !drv_en |-> !drv_lvl);

  // R2
  up_start_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(up) |-> $past(rise_ref));

  // R2
  up_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(up) |-> $past(rise_fb));

  // R3
  dn_start_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(dn) |-> $past(rise_fb));

  // R5
  same_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_ref && rise_fb && !up && !dn) |=> (!up && !dn));

  // R7
  up_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (up && !rise_fb) |=> up);
endmodule

bind edge_pfd edge_pfd_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rise_ref (rise_ref),
  .rise_fb  (rise_fb),
  .up       (flag_up),
  .dn       (flag_dn),
  .drv_en   (drv_en),
  .drv_lvl  (drv_lvl)
);

// File: tb/edge_pfd_test.sv
module edge_pfd_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;
  logic drv_en, drv_lvl, phase_flag;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_pfd uut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .drv_en(drv_en), .drv_lvl(drv_lvl), .phase_flag(phase_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Behavioural reference: input sample history queues and two pending flags
  bit hist_r[$] = '{0, 0, 0};
  bit hist_f[$] = '{0, 0, 0};
  bit m_up = 0;
  bit m_dn = 0;

  always @(posedge clk) begin
    bit er, ef, a, b;
    if (!rst_n) begin
      m_up = 0; m_dn = 0;
      hist_r = '{0, 0, 0};
      hist_f = '{0, 0, 0};
    end else begin
      er = hist_r[1] && !hist_r[2];
      ef = hist_f[1] && !hist_f[2];
      a = m_up || er;
      b = m_dn || ef;
      if (a && b) begin m_up = 0; m_dn = 0; end
      else begin m_up = a; m_dn = b; end
      void'(hist_r.pop_back());
      void'(hist_f.pop_back());
      hist_r.push_front(ref_in);
      hist_f.push_front(fb_in);
    end
  end

  // Per-cycle comparison and pulse measurement, away from the active edge
  int run_len = 0;
  bit run_lvl = 0;
  int last_len = 0;
  bit last_lvl = 0;
  int pulses = 0;

  always @(negedge clk) begin
    bit e_en, e_lvl;
    e_en  = rst_n && (m_up || m_dn);
    e_lvl = rst_n && m_up;
    chk(drv_en === e_en, "R2/R3 drv_en model", int'(drv_en), int'(e_en));
    chk(drv_lvl === e_lvl, "R4 drv_lvl model", int'(drv_lvl), int'(e_lvl));
    chk(phase_flag === drv_en, "R6 phase_flag", int'(phase_flag), int'(drv_en));
    if (drv_en === 1'b1) begin
      if (run_len == 0) run_lvl = drv_lvl;
      run_len++;
    end else if (run_len != 0) begin
      last_len = run_len;
      last_lvl = run_lvl;
      run_len = 0;
      pulses++;
    end
  end

  task automatic step(input bit r, input bit f);
    @(negedge clk);
    ref_in = r;
    fb_in = f;
  endtask

  // Rising edges at relative cycles ra / fa, each held high for rh / fh cycles
  task automatic pair(input int ra, input int fa, input int rh, input int fh);
    int span;
    span = ((ra + rh > fa + fh) ? ra + rh : fa + fh) + 8;
    for (int t = 0; t < span; t++)
      step(t >= ra && t < ra + rh, t >= fa && t < fa + fh);
  endtask

  task automatic expect_pulse(input int p0, input int len, input bit lvl, input string req);
    chk(pulses == p0 + 1, req, pulses - p0, 1);
    chk(last_len == len, req, last_len, len);
    chk(last_lvl == lvl, req, int'(last_lvl), int'(lvl));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int p0;
    // R8: reset state
    repeat (3) @(negedge clk);
    chk(drv_en == 0 && phase_flag == 0, "R8 reset state", int'(drv_en), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(drv_en == 0 && drv_lvl == 0, "R4 idle released", int'(drv_en), 0);

    // R2: reference leads by 5
    p0 = pulses; pair(0, 5, 3, 3); expect_pulse(p0, 5, 1, "R2 lead width");
    // R3: feedback leads by 7
    p0 = pulses; pair(7, 0, 4, 4); expect_pulse(p0, 7, 0, "R3 lag width");
    // R1: narrow reference, wide feedback, and the reverse
    p0 = pulses; pair(0, 4, 1, 9); expect_pulse(p0, 4, 1, "R1 duty lead");
    p0 = pulses; pair(6, 0, 1, 12); expect_pulse(p0, 6, 0, "R1 duty lag");
    p0 = pulses; pair(0, 4, 9, 1); expect_pulse(p0, 4, 1, "R1 duty wide ref");
    // R5: same-cycle edges
    p0 = pulses; pair(3, 3, 2, 5);
    chk(pulses == p0, "R5 equal phase no pulse", pulses - p0, 0);

    // R9: latency of two edges after first capture
    step(1, 0);
    @(negedge clk); chk(drv_en == 0, "R9 latency edge k", int'(drv_en), 0);
    @(negedge clk); chk(drv_en == 0, "R9 latency edge k+1", int'(drv_en), 0);
    @(negedge clk); chk(drv_en == 1, "R9 latency edge k+2", int'(drv_en), 1);
    step(0, 1); repeat (6) step(0, 0);

    // R7: second reference edge while driving high
    p0 = pulses;
    step(1, 0); step(1, 0); step(0, 0); step(0, 0); step(1, 0); step(1, 0);
    repeat (4) step(0, 0);
    step(0, 1); step(0, 1);
    repeat (8) step(0, 0);
    expect_pulse(p0, 10, 1, "R7 repeated ref edges");

    // Unequal frequencies: ref period 20, feedback period 26
    p0 = pulses;
    for (int t = 0; t < 780; t++) step((t % 20) < 10, (t % 26) < 5);
    repeat (8) step(0, 0);
    chk(pulses > p0 + 10, "R7 unequal frequency pulses", pulses - p0, 11);

    // R8: asynchronous reset during an active pulse
    step(1, 0);
    repeat (5) @(negedge clk);
    chk(drv_en == 1, "R8 pulse before reset", int'(drv_en), 1);
    #2 rst_n = 1'b0;
    #1 chk(drv_en == 0 && phase_flag == 0, "R8 async clear", int'(drv_en), 0);
    ref_in = 0; fb_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(drv_en == 0, "R8 released after reset", int'(drv_en), 0);
    p0 = pulses; pair(0, 3, 2, 2); expect_pulse(p0, 3, 1, "R8 resumes after reset");

    finish_run();
  end
endmodule